// File: doc/BRIEF.md
# Sinc Decimation Front End for a One-Bit Modulator Stream

This block turns the one-bit output of a sigma-delta modulator, taken once per clock, into decimated conversion words. A two-bit mode input selects one of three behaviours. The first is a self-contained second-order sinc converter with a fixed conversion period. Its result is complete and needs no further processing. The other two are filter modes of second or third order. They run a chain of wrapping integrators over a period that software programs, and at the end of each period they hand out a raw integrator snapshot.

In the filter modes the first comb stage is already absorbed in hardware. At the start of every period the last integrator of the chain begins again from zero. Downstream logic therefore applies only one difference (second order) or two differences (third order) to consecutive words to obtain the filtered value, and all of that arithmetic is modulo 2^27. Each finished period raises a ready pulse that lasts one clock. The data word then holds until the next pulse. The first word after enabling, or after any change of mode or period, covers an incomplete history and should be discarded by the consumer. The modulator itself, input selection and gain are outside this block.

Top module: `sinc_decim_front`

## Requirements
- R1: `mode` selects the behaviour: 2'b00 is the fixed-period sinc2 converter, 2'b01 is the sinc2 filter, 2'b10 is the sinc3 filter, and 2'b11 behaves exactly like 2'b10.
- R2: In mode 2'b00 the period is fixed at 64 clocks. Each output is the second difference of the second integrator's value taken at successive period ends, zero-extended from 13 bits. With a constant one at the input the first word after enable is 2080 and every later word is 4096.
- R3: In mode 2'b01 each word is the sum, over the cycles of one period, of the running count of ones since enable, where that count includes the current cycle. With a constant one at the input and period P, the difference between consecutive words is P*P from the second word on.
- R4: In mode 2'b10 each word is the sum, over one period, of the second integrator. With a constant one at the input and period P, the second difference of consecutive words equals P*P*P modulo 2^27 from the third word on.
- R5: All integrators and filter-mode words are 27 bits wide and wrap modulo 2^27 without saturating.
- R6: In the filter modes the period is `period` clocks. Values below 8 act as 8, and any value up to 16383 is accepted. With period 3 the ready pulses are 8 clocks apart, and with 8192 they are 8192 apart.
- R7: `ready` is high for exactly one clock per finished period, and `data_out` changes only in the clock in which `ready` rises.
- R8: While `en` is low the integrators and the period count are cleared, `ready` stays low and `data_out` keeps its last value. After `en` rises, the first ready pulse appears P clocks later.
- R9: A change of `mode` or `period` while enabled restarts the conversion. That clock's input bit is dropped, and the next ready pulse appears P+1 clocks after the change.
- R10: After reset `data_out` is zero and `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulator bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the converter; low clears its state |
| bit_in | input | 1 | Modulator bitstream |
| mode | input | 2 | Behaviour select (see R1) |
| period | input | 14 | Decimation period in clocks for the filter modes |
| data_out | output | 27 | Latest conversion word |
| ready | output | 1 | One-clock pulse when a new word is present |

## Verification
The assertions assume that `mode` and `period` change only between clock edges and that `period` is either at least the minimum or meant to be clamped. They also assume that the bench never looks at `data_out` as valid except in the clock where `ready` is high. The stimulus drives every input on the falling edge and leaves mode and period changes to moments when the bench expects a restart. The stimulus covers all-ones, all-zeros and pseudo-random bitstreams, periods below the minimum and at the top of the sinc2 range, and mid-period changes and disables, so that each restart and clearing path is exercised.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

  // Width of every integrator and of the filter-mode result.
  localparam int ACC_W = 27;

  typedef enum logic [1:0] {
    MODE_SAMPLE = 2'b00,
    MODE_FILT2  = 2'b01,
    MODE_FILT3  = 2'b10,
    MODE_FILT3B = 2'b11
  } conv_mode_e;

  // True when integrator stage g restarts from zero at the start of each
  // period: this realises the folded first comb of the filter modes.
  function automatic logic stage_restarts(input logic [1:0] m, input int unsigned g);
    return ((m == MODE_FILT2) && (g == 1)) || (m[1] && (g == 2));
  endfunction

  // True when the selected mode returns the fully combed sinc2 result.
  function automatic logic is_sample_mode(input logic [1:0] m);
    return m == MODE_SAMPLE;
  endfunction

  // Effective period: the fixed value in sample mode, else the clamped request.
  function automatic int unsigned effective_period(input logic [1:0] m,
                                                   input int unsigned req,
                                                   input int unsigned lo,
                                                   input int unsigned fixed);
    if (m == MODE_SAMPLE) return fixed;
    return (req < lo) ? lo : req;
  endfunction

endpackage

// File: rtl/sinc_period_timer.sv
module sinc_period_timer #(
  parameter int PER_W       = 14,
  parameter int PER_MIN     = 8,
  parameter int SAMPLE_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] count,
  output logic [PER_W-1:0] eff,
  output logic             first,
  output logic             last
);
  import sinc_pkg::*;

  localparam int SAMPLE_PERIOD = 1 << SAMPLE_LOG2;

  logic [PER_W-1:0] count_r;

  assign eff   = PER_W'(effective_period(mode, 32'(period), PER_MIN, SAMPLE_PERIOD));
  assign first = (count_r == '0);
  assign last  = (count_r == (eff - PER_W'(1)));
  assign count = count_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_r <= '0;
    end else if (clear) begin
      count_r <= '0;
    end else if (run) begin
      count_r <= last ? '0 : (count_r + PER_W'(1));
    end
  end

endmodule

// File: rtl/sinc_integrators.sv
module sinc_integrators #(
  parameter int ACC_W  = 27,
  parameter int STAGES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         run,
  input  logic                         bit_in,
  input  logic [STAGES-1:0]            zero_base,
  output logic [STAGES-1:0][ACC_W-1:0] nxt
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [ACC_W-1:0] acc_r;
    logic [ACC_W-1:0] feed;
    logic [ACC_W-1:0] base;

    if (g == 0) begin : g_head
      assign feed = {{(ACC_W-1){1'b0}}, bit_in};
    end else begin : g_tail
      assign feed = nxt[g-1];
    end

    assign base   = zero_base[g] ? '0 : acc_r;
    assign nxt[g] = base + feed;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_r <= '0;
      end else if (clear) begin
        acc_r <= '0;
      end else if (run) begin
        acc_r <= nxt[g];
      end
    end
  end

endmodule

// File: rtl/sinc_sample_comb.sv
module sinc_sample_comb #(
  parameter int ACC_W = 27,
  parameter int OUT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             strobe,
  input  logic [ACC_W-1:0] sum_in,
  output logic [OUT_W-1:0] result
);

  logic [ACC_W-1:0] z1_r;
  logic [ACC_W-1:0] z2_r;
  logic [ACC_W-1:0] c1;
  logic [ACC_W-1:0] c2;

  assign c1     = sum_in - z1_r;
  assign c2     = c1 - z2_r;
  assign result = c2[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z1_r <= '0;
      z2_r <= '0;
    end else if (clear) begin
      z1_r <= '0;
      z2_r <= '0;
    end else if (strobe) begin
      z1_r <= sum_in;
      z2_r <= c1;
    end
  end

endmodule

// File: rtl/sinc_decim_front.sv
module sinc_decim_front #(
  parameter int PER_W       = 14,
  parameter int PER_MIN     = 8,
  parameter int SAMPLE_LOG2 = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      bit_in,
  input  logic [1:0]                mode,
  input  logic [PER_W-1:0]          period,
  output logic [sinc_pkg::ACC_W-1:0] data_out,
  output logic                      ready
);
  import sinc_pkg::*;

  localparam int STAGES = 3;
  localparam int SAMP_W = 2 * SAMPLE_LOG2 + 1;

  // Named internal events, brought out for the checker.
  logic             restart;
  logic             clear;
  logic             run;
  logic             boundary;
  logic             period_first;
  logic             period_last;
  logic [PER_W-1:0] count;
  logic [PER_W-1:0] eff;

  logic [1:0]       mode_q;
  logic [PER_W-1:0] period_q;

  logic [STAGES-1:0]            zero_base;
  logic [STAGES-1:0][ACC_W-1:0] stage_nxt;
  logic [SAMP_W-1:0]            sample_word;
  logic [ACC_W-1:0]             filter_word;
  logic [ACC_W-1:0]             data_r;
  logic                         ready_r;

  assign restart  = en && ((mode != mode_q) || (period != period_q));
  assign clear    = !en || restart;
  assign run      = en && !restart;
  assign boundary = run && period_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      period_q <= '0;
    end else begin
      mode_q   <= mode;
      period_q <= period;
    end
  end

  sinc_period_timer #(
    .PER_W      (PER_W),
    .PER_MIN    (PER_MIN),
    .SAMPLE_LOG2(SAMPLE_LOG2)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .run   (run),
    .mode  (mode),
    .period(period),
    .count (count),
    .eff   (eff),
    .first (period_first),
    .last  (period_last)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_zero
    assign zero_base[g] = period_first && stage_restarts(mode, g);
  end

  sinc_integrators #(
    .ACC_W (ACC_W),
    .STAGES(STAGES)
  ) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .run      (run),
    .bit_in   (bit_in),
    .zero_base(zero_base),
    .nxt      (stage_nxt)
  );

  sinc_sample_comb #(
    .ACC_W(ACC_W),
    .OUT_W(SAMP_W)
  ) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .strobe(boundary && is_sample_mode(mode)),
    .sum_in(stage_nxt[1]),
    .result(sample_word)
  );

  assign filter_word = (mode == MODE_FILT2) ? stage_nxt[1] : stage_nxt[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_r  <= '0;
      ready_r <= 1'b0;
    end else begin
      ready_r <= boundary;
      if (boundary) begin
        data_r <= is_sample_mode(mode) ? {{(ACC_W-SAMP_W){1'b0}}, sample_word}
                                       : filter_word;
      end
    end
  end

  assign data_out = data_r;
  assign ready    = ready_r;

endmodule

// File: rtl/sinc_checker.sv
module sinc_checker #(
  parameter int PER_W = 14,
  parameter int ACC_W = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             ready,
  input logic [ACC_W-1:0] data_out,
  input logic             boundary,
  input logic             restart,
  input logic [PER_W-1:0] count,
  input logic [PER_W-1:0] eff
);

  // R7: a ready pulse never lasts two clocks
  a_r7_ready_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R7: every finished period is announced on the next clock
  a_r7_ready_follows_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> ready);

  // R7: the word holds between period ends
  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(data_out));

  // R8: nothing is announced while disabled
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready);

  // R9: a restart returns the period count to zero
  a_r9_restart_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

  // R6: the count stays inside the effective period
  a_r6_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (count < eff));

endmodule

bind sinc_decim_front sinc_checker #(
  .PER_W(PER_W),
  .ACC_W(sinc_pkg::ACC_W)
) u_sinc_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .ready   (ready),
  .data_out(data_out),
  .boundary(boundary),
  .restart (restart),
  .count   (count),
  .eff     (eff)
);

// File: tb/tb_sinc_decim_front.sv
module tb_sinc_decim_front;

  localparam int  CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 150000;
  localparam longint MASK    = (64'd1 << 27) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        bit_in = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [13:0] period = 14'd0;
  logic [26:0] data_out;
  logic        ready;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;

  // 0: all ones, 1: pseudo-random, 2: all zeros
  int       src = 0;
  logic [15:0] lfsr = 16'hACE1;

  sinc_decim_front dut (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_in(bit_in),
    .mode(mode), .period(period), .data_out(data_out), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Bitstream source, driven away from the active edge
  always @(negedge clk) begin
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bit_in <= (src == 0) ? 1'b1 : (src == 2) ? 1'b0 : lfsr[0];
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: running tallies as integers
  longint m_ones, m_s2, m_s3, m_z1, m_z2, m_ph;
  longint e_data = 0;
  bit     e_rdy  = 0;
  int     m_pm = 0, m_pp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ones = 0; m_s2 = 0; m_s3 = 0; m_z1 = 0; m_z2 = 0; m_ph = 0;
      e_data = 0; e_rdy = 0; m_pm = 0; m_pp = 0;
    end else begin
      e_rdy = 0;
      if (!en || int'(mode) != m_pm || int'(period) != m_pp) begin
        m_ones = 0; m_s2 = 0; m_s3 = 0; m_z1 = 0; m_z2 = 0; m_ph = 0;
      end else begin
        longint n;
        m_ones = (m_ones + longint'(bit_in)) & MASK;
        m_s2   = (((m_ph == 0 && mode == 2'b01) ? 0 : m_s2) + m_ones) & MASK;
        m_s3   = (((m_ph == 0 && mode[1]) ? 0 : m_s3) + m_s2) & MASK;
        n = (mode == 2'b00) ? 64 : ((period < 8) ? 8 : longint'(period));
        if (m_ph == n - 1) begin
          e_rdy = 1;
          if (mode == 2'b00) begin
            longint c1, c2;
            c1 = (m_s2 - m_z1) & MASK;
            m_z1 = m_s2;
            c2 = (c1 - m_z2) & MASK;
            m_z2 = c1;
            e_data = c2 & 64'h1FFF;
          end else begin
            e_data = (mode == 2'b01) ? m_s2 : m_s3;
          end
          m_ph = 0;
        end else begin
          m_ph = m_ph + 1;
        end
      end
      m_pm = int'(mode);
      m_pp = int'(period);
    end
  end

  // Per-cycle comparison and word capture
  longint wq[$];
  longint cq[$];
  bit     prev_rdy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 ready vs model", longint'(ready), longint'(e_rdy));
      check(mode == 2'b00 ? "R2 data vs model" :
            mode == 2'b01 ? "R3 data vs model" : "R4 data vs model",
            longint'(data_out), e_data);
      if (ready) begin
        check("R7 ready not two wide", longint'(prev_rdy), 0);
        wq.push_back(longint'(data_out));
        cq.push_back(cyc);
      end
      prev_rdy = ready;
    end
  end

  task automatic wait_words(input int n);
    while (wq.size() < n) @(negedge clk);
  endtask

  task automatic start(input logic [1:0] m, input int p, input int s);
    @(negedge clk);
    en = 1'b0; mode = m; period = 14'(p); src = s;
    repeat (3) @(negedge clk);
    wq.delete(); cq.delete();
    en = 1'b1;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint c0, d, dd;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 data after reset", longint'(data_out), 0);
    check("R10 ready after reset", longint'(ready), 0);
    rst_n = 1'b1;

    // R2: fixed-period sinc2
    start(2'b00, 20, 0);
    wait_words(3);
    check("R2 first word", wq[0], 2080);
    check("R2 second word", wq[1], 4096);
    check("R2 third word", wq[2], 4096);
    src = 1; wait_words(8);

    // R3: sinc2 filter, one downstream difference
    start(2'b01, 20, 0);
    wait_words(3);
    check("R3 first word", wq[0], 210);
    check("R3 diff 1", wq[1] - wq[0], 400);
    check("R3 diff 2", wq[2] - wq[1], 400);
    src = 1; wait_words(10);

    // R4 / R1: sinc3 filter, two downstream differences; 11 behaves as 10
    for (int k = 0; k < 2; k++) begin
      start(k == 0 ? 2'b10 : 2'b11, 16, 0);
      wait_words(5);
      for (int i = 2; i < 5; i++) begin
        dd = (wq[i] - 2 * wq[i-1] + wq[i-2]) & MASK;
        check(k == 0 ? "R4 second diff" : "R1 mode 11 second diff", dd, 4096);
      end
    end

    // R5: wrap modulo 2^27 (512^3 = 2^27)
    start(2'b10, 512, 0);
    wait_words(4);
    dd = (wq[3] - 2 * wq[2] + wq[1]) & MASK;
    check("R5 wrapped second diff", dd, 0);
    check("R5 word within 27 bits", wq[3] >> 27, 0);

    // R6: clamp and long period
    start(2'b01, 3, 1);
    wait_words(3);
    check("R6 clamped spacing", cq[2] - cq[1], 8);
    start(2'b01, 8192, 1);
    wait_words(2);
    check("R6 long spacing", cq[1] - cq[0], 8192);

    // R9: change while enabled
    start(2'b01, 20, 1);
    wait_words(2);
    repeat (7) @(negedge clk);
    period = 14'd30; c0 = cyc;
    wq.delete(); cq.delete();
    wait_words(1);
    check("R9 period change restart", cq[0] - c0, 31);
    repeat (5) @(negedge clk);
    mode = 2'b10; c0 = cyc;
    wq.delete(); cq.delete();
    wait_words(1);
    check("R9 mode change restart", cq[0] - c0, 31);

    // R8: disable mid-period holds data and suppresses ready
    repeat (9) @(negedge clk);
    en = 1'b0; d = longint'(data_out);
    wq.delete();
    repeat (60) @(negedge clk);
    check("R8 no ready while off", wq.size(), 0);
    check("R8 data held while off", longint'(data_out), d);
    src = 2; en = 1'b1; c0 = cyc;
    wq.delete(); cq.delete();
    wait_words(1);
    check("R8 first ready after enable", cq[0] - c0, 30);
    check("R8 zeros give zero word", wq[0], 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule